// File: doc/BRIEF.md
# Beam-Synchronised Display List Sequencer

This block walks a list of 32-bit instructions held in memory and replays them against the video beam. Each instruction is two 16-bit words fetched one after the other from a word-addressed read port. There are three instruction kinds. A register write puts a 16-bit immediate onto a chip-register write bus. A beam wait stalls the list until the beam has reached a target position. A conditional skip steps over the following instruction when the beam has already passed a target position. A fixed all-ones wait ends the list.

Two list start locations are held inside the block. The list itself sets them through its own register writes, and a write to either of two restart addresses redirects fetching to one of them. Every vertical blank pulse sends execution back to the first location, so the list runs once per frame. Writes to the low part of the register space are blocked unless a guard-override input is high. A blocked write sets a sticky error output.

Top module: `beamListSeq`

## Requirements
- R1: While reset is applied and on release, regWe and errFlag are low, memReq is high and memAddr equals the first-location reset value (0 by default).
- R2: An instruction whose first word has bit 0 clear writes the whole second word to register address first-word[8:0]. Writes appear on the bus in list order. With a memory that acknowledges at once, consecutive writes are three clocks apart.
- R3: An instruction with first-word bit 0 set and second-word bit 0 clear is a wait. Its vertical target is first-word[15:8] and its horizontal target is first-word[7:1]. Second-word[14:8] enables compare on vertical bits 6:0 (vertical bit 7 is always compared), and second-word[7:1] enables compare on horizontal bits 6:0. The wait ends once the masked beam is at or beyond the masked target, judged on the vertical position first and the horizontal position on a vertical tie.
- R4: When second-word bit 15 of a wait is 0, the wait also needs blitBusy low before it ends. When the bit is 1, blitBusy is ignored.
- R5: An instruction with both bit 0 flags set is a skip. If the masked compare of R3 holds, the next instruction is not executed. Otherwise execution continues with it. blitBusy plays no part.
- R6: The pair 0xFFFF, 0xFFFE halts the sequencer: memReq stays low and no writes occur, whatever the beam position, until vertical blank.
- R7: Writes to 0x080/0x084 set address bits 17:15 of location 1/2 from data[2:0]. Writes to 0x082/0x086 set bits 14:0 from data[14:0]. A write to 0x088 (0x08A) makes the next fetch come from location 1 (2). All of these writes also appear on the bus.
- R8: vblank high at a clock edge restarts fetching at location 1 from any state, including a pending wait and a halt.
- R9: With dangerEn low, a write to an address below 0x040 does not reach the bus and sets errFlag, which stays set until reset. With dangerEn high, the write goes through.
- R10: If vblank is high at the edge where a register write would be issued, that write is dropped and fetching restarts at location 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memReq | output | 1 | Instruction word read request |
| memAddr | output | 18 | Word address of the requested word |
| memAck | input | 1 | Read acknowledge, data valid this cycle |
| memData | input | 16 | Read data |
| regWe | output | 1 | Register write strobe |
| regAddr | output | 9 | Register write address |
| regData | output | 16 | Register write data |
| beamV | input | 8 | Vertical beam position |
| beamH | input | 7 | Horizontal beam position |
| vblank | input | 1 | Vertical blank pulse, restarts the list |
| blitBusy | input | 1 | Blitter still running |
| dangerEn | input | 1 | Allows writes to the guarded low register range |
| errFlag | output | 1 | Sticky flag for a blocked write |

## Verification
Two events can land on the same clock edge: the frame restart and the issue of a register write. The bench finds when the first write of a two-write list appears on the bus and counts forward to the edge that ends the second instruction's execute cycle. It raises vblank for exactly that edge. It then expects the second write to be missing, and the first write to appear again six clocks after its first appearance. The outcome is judged on the write bus alone.

// File: rtl/beamListPkg.sv
`timescale 1ns/1ps
package beamListPkg;
  localparam int WORD_W  = 16;
  localparam int RADDR_W = 9;
  localparam int V_W     = 8;
  localparam int H_W     = 7;

  localparam logic [RADDR_W-1:0] LOC1_HI = 9'h080;
  localparam logic [RADDR_W-1:0] LOC1_LO = 9'h082;
  localparam logic [RADDR_W-1:0] LOC2_HI = 9'h084;
  localparam logic [RADDR_W-1:0] LOC2_LO = 9'h086;
  localparam logic [RADDR_W-1:0] JUMP1   = 9'h088;
  localparam logic [RADDR_W-1:0] JUMP2   = 9'h08A;

  typedef enum logic [2:0] {
    S_FETCH1, S_FETCH2, S_EXEC, S_WAITS, S_HALT
  } seqState_e;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic ldW1;
    logic ldW2;
    logic pcInc;
    logic pcSkip;
    logic pcReload;
    logic issueWrite;
    logic flagErr;
  } seqStrobe_t;

  // masked beam >= masked target, vertical first, horizontal on a tie
  function automatic logic beamHit(input logic [V_W-1:0] bv, input logic [H_W-1:0] bh,
                                   input logic [WORD_W-1:0] w1, input logic [WORD_W-1:0] w2);
    logic [V_W-1:0] vMask;
    logic [H_W-1:0] hMask;
    logic [V_W-1:0] vb, vt;
    logic [H_W-1:0] hb, ht;
    vMask = {1'b1, w2[14:8]};
    hMask = w2[7:1];
    vb = bv & vMask;
    vt = w1[15:8] & vMask;
    hb = bh & hMask;
    ht = w1[7:1] & hMask;
    return (vb > vt) || ((vb == vt) && (hb >= ht));
  endfunction
endpackage

// File: rtl/beamListCtrl.sv
`timescale 1ns/1ps
module beamListCtrl
  import beamListPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       vblank,
  input  logic       memAck,
  input  logic       isMove,
  input  logic       isSkip,
  input  logic       isEnd,
  input  logic       cmpHit,
  input  logic       blitOk,
  input  logic       moveOk,
  output logic       memReq,
  output seqStrobe_t strobe
);
  seqState_e stQ, stNext;

  always_comb begin
    strobe = '0;
    stNext = stQ;
    memReq = (stQ == S_FETCH1) || (stQ == S_FETCH2);
    if (vblank) begin
      strobe.pcReload = 1'b1;
      stNext = S_FETCH1;
    end else begin
      case (stQ)
        S_FETCH1: if (memAck) begin
          strobe.ldW1  = 1'b1;
          strobe.pcInc = 1'b1;
          stNext = S_FETCH2;
        end
        S_FETCH2: if (memAck) begin
          strobe.ldW2  = 1'b1;
          strobe.pcInc = 1'b1;
          stNext = S_EXEC;
        end
        S_EXEC: begin
          if (isMove) begin
            strobe.issueWrite = moveOk;
            strobe.flagErr    = !moveOk;
            stNext = S_FETCH1;
          end else if (isEnd) begin
            stNext = S_HALT;
          end else if (isSkip) begin
            strobe.pcSkip = cmpHit;
            stNext = S_FETCH1;
          end else begin
            stNext = S_WAITS;
          end
        end
        S_WAITS: if (cmpHit && blitOk) stNext = S_FETCH1;
        S_HALT:  stNext = S_HALT;
        default: stNext = S_FETCH1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= S_FETCH1;
    else       stQ <= stNext;
  end

  // R3: an unmet beam compare keeps the wait pending
  a_r3_wait_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == S_WAITS && !cmpHit && !vblank) |=> (stQ == S_WAITS));

  // R4: a busy blitter keeps a guarded wait pending
  a_r4_blit_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == S_WAITS && !blitOk && !vblank) |=> (stQ == S_WAITS));
endmodule

// File: rtl/beamListPath.sv
`timescale 1ns/1ps
module beamListPath
  import beamListPkg::*;
#(
  parameter int HI_W = 3,
  parameter int LO_W = 15,
  parameter logic [HI_W+LO_W-1:0] LOC1_RST = '0,
  parameter logic [HI_W+LO_W-1:0] LOC2_RST = '0,
  parameter logic [RADDR_W-1:0] DANGER_LIM = 9'h040
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strobe,
  input  logic [WORD_W-1:0]      memData,
  input  logic [V_W-1:0]         beamV,
  input  logic [H_W-1:0]         beamH,
  input  logic                   blitBusy,
  input  logic                   dangerEn,
  input  logic                   vblank,
  output logic [HI_W+LO_W-1:0]   memAddr,
  output logic                   regWe,
  output logic [RADDR_W-1:0]     regAddr,
  output logic [WORD_W-1:0]      regData,
  output logic                   errFlag,
  output logic                   isMove,
  output logic                   isSkip,
  output logic                   isEnd,
  output logic                   cmpHit,
  output logic                   blitOk,
  output logic                   moveOk
);
  localparam int ADDR_W = HI_W + LO_W;

  logic [WORD_W-1:0]  w1Q, w2Q;
  logic [ADDR_W-1:0]  pcQ, loc1Q, loc2Q;
  logic [RADDR_W-1:0] dstAddr;

  assign dstAddr = w1Q[RADDR_W-1:0];
  assign isMove  = !w1Q[0];
  assign isEnd   = (w1Q == 16'hFFFF) && (w2Q == 16'hFFFE);
  assign isSkip  = w1Q[0] && w2Q[0];
  assign cmpHit  = beamHit(beamV, beamH, w1Q, w2Q);
  assign blitOk  = w2Q[15] || !blitBusy;
  assign moveOk  = dangerEn || (dstAddr >= DANGER_LIM);
  assign memAddr = pcQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      w1Q     <= '0;
      w2Q     <= '0;
      pcQ     <= LOC1_RST;
      loc1Q   <= LOC1_RST;
      loc2Q   <= LOC2_RST;
      regWe   <= 1'b0;
      regAddr <= '0;
      regData <= '0;
      errFlag <= 1'b0;
    end else begin
      if (strobe.ldW1) w1Q <= memData;
      if (strobe.ldW2) w2Q <= memData;
      if (strobe.flagErr) errFlag <= 1'b1;
      regWe <= strobe.issueWrite;
      if (strobe.issueWrite) begin
        regAddr <= dstAddr;
        regData <= w2Q;
        case (dstAddr)
          LOC1_HI: loc1Q[ADDR_W-1:LO_W] <= w2Q[HI_W-1:0];
          LOC1_LO: loc1Q[LO_W-1:0]      <= w2Q[LO_W-1:0];
          LOC2_HI: loc2Q[ADDR_W-1:LO_W] <= w2Q[HI_W-1:0];
          LOC2_LO: loc2Q[LO_W-1:0]      <= w2Q[LO_W-1:0];
          default: ;
        endcase
      end
      if (strobe.pcReload)
        pcQ <= loc1Q;
      else if (strobe.issueWrite && dstAddr == JUMP1)
        pcQ <= loc1Q;
      else if (strobe.issueWrite && dstAddr == JUMP2)
        pcQ <= loc2Q;
      else if (strobe.pcSkip)
        pcQ <= pcQ + ADDR_W'(2);
      else if (strobe.pcInc)
        pcQ <= pcQ + ADDR_W'(1);
    end
  end

  // R2: writes never come back to back
  a_r2_spacing: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R8: a blank pulse points fetching at location 1
  a_r8_reload: assert property (@(posedge clk) disable iff (!rstN)
    vblank |=> (pcQ == $past(loc1Q)));

  // R9: guarded addresses reach the bus only with the override
  a_r9_guard: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> ((regAddr >= DANGER_LIM) || $past(dangerEn)));

  // R10: no write is issued in the cycle after a blank pulse
  a_r10_vblank_wins: assert property (@(posedge clk) disable iff (!rstN)
    vblank |=> !regWe);
endmodule

// File: rtl/beamListSeq.sv
`timescale 1ns/1ps
module beamListSeq
  import beamListPkg::*;
#(
  parameter int HI_W = 3,
  parameter int LO_W = 15,
  parameter logic [HI_W+LO_W-1:0] LOC1_RST = '0,
  parameter logic [HI_W+LO_W-1:0] LOC2_RST = '0,
  parameter logic [8:0] DANGER_LIM = 9'h040
)(
  input  logic                 clk,
  input  logic                 rstN,
  output logic                 memReq,
  output logic [HI_W+LO_W-1:0] memAddr,
  input  logic                 memAck,
  input  logic [15:0]          memData,
  output logic                 regWe,
  output logic [8:0]           regAddr,
  output logic [15:0]          regData,
  input  logic [7:0]           beamV,
  input  logic [6:0]           beamH,
  input  logic                 vblank,
  input  logic                 blitBusy,
  input  logic                 dangerEn,
  output logic                 errFlag
);
  seqStrobe_t strobe;
  logic isMove, isSkip, isEnd, cmpHit, blitOk, moveOk;

  beamListCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .vblank(vblank), .memAck(memAck),
    .isMove(isMove), .isSkip(isSkip), .isEnd(isEnd), .cmpHit(cmpHit),
    .blitOk(blitOk), .moveOk(moveOk), .memReq(memReq), .strobe(strobe)
  );

  beamListPath #(
    .HI_W(HI_W), .LO_W(LO_W), .LOC1_RST(LOC1_RST), .LOC2_RST(LOC2_RST),
    .DANGER_LIM(DANGER_LIM)
  ) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memData(memData),
    .beamV(beamV), .beamH(beamH), .blitBusy(blitBusy), .dangerEn(dangerEn),
    .vblank(vblank), .memAddr(memAddr), .regWe(regWe), .regAddr(regAddr),
    .regData(regData), .errFlag(errFlag), .isMove(isMove), .isSkip(isSkip),
    .isEnd(isEnd), .cmpHit(cmpHit), .blitOk(blitOk), .moveOk(moveOk)
  );
endmodule

// File: tb/test_beamListSeq.sv
`timescale 1ns/1ps
module test_beamListSeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memReq, memAck;
  logic [17:0] memAddr;
  logic [15:0] memData;
  logic        regWe;
  logic [8:0]  regAddr;
  logic [15:0] regData;
  logic [7:0]  beamV = '0;
  logic [6:0]  beamH = '0;
  logic        vblank = 1'b0, blitBusy = 1'b0, dangerEn = 1'b0;
  logic        errFlag;

  beamListSeq i_beamListSeq (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memAddr(memAddr), .memAck(memAck),
    .memData(memData), .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .beamV(beamV), .beamH(beamH), .vblank(vblank), .blitBusy(blitBusy),
    .dangerEn(dangerEn), .errFlag(errFlag)
  );

  always #2 clk = ~clk;

  logic [15:0] memLo [64];
  logic [15:0] memHi [64];
  assign memAck  = memReq;
  assign memData = (memAddr[17:6] == 12'h000) ? memLo[memAddr[5:0]] :
                   (memAddr[17:6] == 12'h200) ? memHi[memAddr[5:0]] :
                   (memAddr[0] ? 16'hFFFE : 16'hFFFF);

  int cyc, logN, wd;
  int logA [32];
  int logD [32];
  int logC [32];
  logic sawHi;
  int total = 0, bad = 0;
  bit done = 0;

  always @(posedge clk) begin
    wd <= wd + 1;
    if (!rstN) cyc <= 0; else cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rstN) begin
      logN  <= 0;
      sawHi <= 1'b0;
    end else begin
      if (memReq && memAddr == 18'h08020) sawHi <= 1'b1;
      if (regWe && logN < 32) begin
        logA[logN] <= int'(regAddr);
        logD[logN] <= int'(regData);
        logC[logN] <= cyc;
        logN <= logN + 1;
      end
    end
  end

  initial wd = 0;
  always @(posedge clk) if (wd > 150000 && !done) begin
    done = 1;
    total++; bad++;
    $display("FAIL watchdog all requirements actual=%0d expected=done", wd);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i += 2) begin
      memLo[i] = 16'hFFFF; memLo[i+1] = 16'hFFFE;
      memHi[i] = 16'hFFFF; memHi[i+1] = 16'hFFFE;
    end
  endtask

  task automatic putMove(bit hi, int idx, int a, int d);
    if (hi) begin memHi[idx] = 16'(a) & 16'h01FE; memHi[idx+1] = 16'(d); end
    else    begin memLo[idx] = 16'(a) & 16'h01FE; memLo[idx+1] = 16'(d); end
  endtask

  task automatic putWait(int idx, int v, int h, int vm, int hm, bit bfd, bit skip);
    memLo[idx]   = {8'(v), 7'(h), 1'b1};
    memLo[idx+1] = {bfd, 7'(vm), 7'(hm), skip};
  endtask

  task automatic start();
    rstN = 1'b0;
    tick(2);
    rstN = 1'b1;
  endtask

  task automatic pulseBlank();
    vblank = 1'b1; tick(1); vblank = 1'b0;
  endtask

  function automatic bit hitRef(int bv, int bh, int tv, int th, int vm, int hm);
    int vmf, a, b, c, d;
    vmf = vm | 128;
    a = bv & vmf; b = tv & vmf; c = bh & hm; d = th & hm;
    return (a > b) || (a == b && c >= d);
  endfunction

  initial begin
    int p;
    clearMem();
    putMove(0, 0, 'h180, 'h1234);
    putMove(0, 2, 'h1A2, 'hABCD);
    putMove(0, 4, 'h0F0, 'h5A5A);
    rstN = 1'b0;
    tick(3);
    // R1 reset state
    chk("R1", "regWe in reset", int'(regWe), 0);
    chk("R1", "errFlag in reset", int'(errFlag), 0);
    chk("R1", "memReq in reset", int'(memReq), 1);
    chk("R1", "memAddr in reset", int'(memAddr), 0);
    rstN = 1'b1;
    tick(20);
    // R2 writes in order, three clocks apart
    chk("R2", "write count", logN, 3);
    chk("R2", "addr0", logA[0], 'h180);
    chk("R2", "data0", logD[0], 'h1234);
    chk("R2", "addr1", logA[1], 'h1A2);
    chk("R2", "data1", logD[1], 'hABCD);
    chk("R2", "addr2", logA[2], 'h0F0);
    chk("R2", "data2", logD[2], 'h5A5A);
    chk("R2", "spacing", logC[1] - logC[0], 3);
    chk("R2", "spacing2", logC[2] - logC[1], 3);
    // R6 halted after end marker
    chk("R6", "memReq halted", int'(memReq), 0);

    // R3 wait on full compare
    clearMem();
    putMove(0, 0, 'h100, 1);
    putWait(2, 20, 8, 'h7F, 'h7F, 1'b1, 1'b0);
    putMove(0, 4, 'h102, 2);
    beamV = 8'd10; beamH = 7'd0;
    start(); tick(30);
    chk("R3", "held below target", logN, 1);
    beamV = 8'd20; beamH = 7'd7;
    tick(10);
    chk("R3", "held on h below", logN, 1);
    beamH = 7'd8;
    tick(10);
    chk("R3", "released at target", logN, 2);
    chk("R3", "next write addr", logA[1], 'h102);

    // R3 masked vertical bits ignored
    clearMem();
    putWait(0, 'h35, 0, 'h0F, 0, 1'b1, 1'b0);
    putMove(0, 2, 'h104, 3);
    beamV = 8'h05; beamH = 7'd0;
    start(); tick(20);
    chk("R3", "masked compare passes", logN, 1);
    // R3 vertical bit 7 always compared
    clearMem();
    putWait(0, 'h85, 0, 0, 0, 1'b1, 1'b0);
    putMove(0, 2, 'h104, 3);
    start(); tick(30);
    chk("R3", "v bit7 always compared", logN, 0);

    // R4 blitter guard
    clearMem();
    putMove(0, 0, 'h100, 1);
    putWait(2, 0, 0, 'h7F, 'h7F, 1'b0, 1'b0);
    putMove(0, 4, 'h102, 2);
    beamV = 8'd50; beamH = 7'd50; blitBusy = 1'b1;
    start(); tick(25);
    chk("R4", "held while blitter busy", logN, 1);
    blitBusy = 1'b0;
    tick(10);
    chk("R4", "released when idle", logN, 2);
    clearMem();
    putMove(0, 0, 'h100, 1);
    putWait(2, 0, 0, 'h7F, 'h7F, 1'b1, 1'b0);
    putMove(0, 4, 'h102, 2);
    blitBusy = 1'b1;
    start(); tick(20);
    chk("R4", "busy ignored when disabled", logN, 2);
    blitBusy = 1'b0;

    // R5 skip sweep over beam, target and masks
    for (int k = 0; k < 48; k++) begin
      int tv, th, bv, bh, vm, hm;
      bit hit;
      tv = (k * 37) % 256; bv = (k * 53 + 11) % 256;
      th = (k * 29) % 128; bh = (k * 71 + 3) % 128;
      vm = (k % 3 == 0) ? 'h7F : ((k % 3 == 1) ? 'h70 : 'h0F);
      hm = (k % 4 == 0) ? 'h7F : ((k % 4 == 1) ? 'h00 : ((k % 4 == 2) ? 'h3C : 'h41));
      if (k % 8 == 5) bv = tv;
      clearMem();
      putWait(0, tv, th, vm, hm, 1'b0, 1'b1);
      putMove(0, 2, 'h180, 'h1111);
      putMove(0, 4, 'h182, 'h2222);
      beamV = 8'(bv); beamH = 7'(bh);
      blitBusy = (k % 2 == 1);
      start(); tick(20);
      hit = hitRef(bv, bh, tv, th, vm, hm);
      chk("R5", "skip write count", logN, hit ? 1 : 2);
      chk("R5", "skip first addr", logA[0], hit ? 'h182 : 'h180);
    end
    blitBusy = 1'b0;

    // R6 end marker holds with beam at maximum, R8 blank restarts it
    clearMem();
    putMove(0, 0, 'h180, 7);
    beamV = 8'hFF; beamH = 7'h7F;
    start(); tick(40);
    chk("R6", "one write then halt", logN, 1);
    chk("R6", "no fetch in halt", int'(memReq), 0);
    pulseBlank(); tick(10);
    chk("R8", "restart after halt", logN, 2);
    chk("R8", "restart addr", logA[1], 'h180);

    // R7 locations and restart addresses
    clearMem();
    putMove(0, 0, 'h084, 1);
    putMove(0, 2, 'h086, 'h20);
    putMove(0, 4, 'h08A, 0);
    putMove(0, 6, 'h181, 9);
    putMove(1, 'h20, 'h182, 2);
    putMove(1, 'h22, 'h088, 0);
    start(); tick(30);
    chk("R7", "hi location fetched", int'(sawHi), 1);
    chk("R7", "w3 addr", logA[3], 'h182);
    chk("R7", "w4 addr", logA[4], 'h088);
    chk("R7", "w5 addr back at loc1", logA[5], 'h084);
    chk("R7", "restart write on bus", logA[2], 'h08A);

    // R8 blank during pending wait
    clearMem();
    putMove(0, 0, 'h180, 1);
    putWait(2, 200, 0, 'h7F, 'h7F, 1'b1, 1'b0);
    putMove(0, 4, 'h182, 2);
    beamV = 8'd0; beamH = 7'd0;
    start(); tick(20);
    chk("R8", "waiting", logN, 1);
    pulseBlank(); tick(10);
    chk("R8", "reload from wait", logN, 2);
    chk("R8", "reload addr", logA[1], 'h180);

    // R9 guarded range
    clearMem();
    putMove(0, 0, 'h03E, 1);
    putMove(0, 2, 'h040, 2);
    putMove(0, 4, 'h000, 3);
    dangerEn = 1'b0;
    start(); tick(25);
    chk("R9", "only unguarded write", logN, 1);
    chk("R9", "unguarded addr", logA[0], 'h040);
    chk("R9", "error sticky", int'(errFlag), 1);
    dangerEn = 1'b1;
    start(); tick(25);
    chk("R9", "override passes all", logN, 3);
    chk("R9", "override addr0", logA[0], 'h03E);
    chk("R9", "no error with override", int'(errFlag), 0);
    dangerEn = 1'b0;

    // R10 blank on the write-issue edge
    clearMem();
    putMove(0, 0, 'h180, 'hAAAA);
    putMove(0, 2, 'h182, 'hBBBB);
    beamV = 8'd0;
    start();
    p = 0;
    while (logN < 1 && p < 50) begin tick(1); p++; end
    tick(1);
    vblank = 1'b1; tick(1); vblank = 1'b0;
    tick(10);
    chk("R10", "second write dropped", logA[1], 'h180);
    chk("R10", "restart distance", logC[1] - logC[0], 6);
    chk("R10", "then list continues", logA[2], 'h182);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule